// File: doc/BRIEF.md
# Deserialised Link Latency Aligner

Each front-end fibre reaches this block through a deserialiser. After every reset, that deserialiser settles at one of two latencies, one clock apart, and which one it picks is random. Each link carries an in-band bunch-crossing-zero (BC0) flag, and each link word holds the samples of three front-end channels. The block counts the clocks from the local BC0 to the flag on each link. It accepts that count only after it has seen the same value on four orbits in a row. If the accepted value is the longer of the two latencies, the block requests a deserialiser reset and measures again. After sixteen such retries it stops, keeps the long latency and raises an error bit for that link.

Every link feeds an eight-entry delay line. The read offset of each delay line is the common target latency minus that link's accepted latency. As a result, every locked link presents the words of the same crossing on the same clock. A locked link checks its BC0 position on every orbit. If the flag is late, early or missing, the link drops its lock, raises a sticky loss-of-sync bit and measures again. A clear strobe from the control registers restarts all links and wipes their status.

Top module: `latency_aligner`

## Requirements
- R1: The measured latency of a link is the number of clocks from a local BC0 cycle (count 0) to the cycle that carries the link BC0 flag. While a link is locked, `link_lat_o` shows the accepted value; otherwise it shows 0.
- R2: A measurement is accepted only after four consecutive orbits give the same value. An orbit with no link BC0, or with a different value, restarts that count.
- R3: When the accepted value equals the link's configured short latency, the link locks and requests no deserialiser reset.
- R4: When the accepted value differs from the short latency and fewer than 16 retries have been used, `deser_rst_o` pulses high for exactly one clock and measurement restarts.
- R5: When a link accepts a non-short value after 16 resets, it sets `retry_err_o`, locks at that value, and issues no further reset.
- R6: On every locked link, the aligned BC0 appears `cfg_target_i`+1 clocks after the local BC0, and the aligned data are the link words delayed by the same amount. All locked links therefore agree on every cycle. The target minus the latency must lie in 0..7.
- R7: On a locked link, a missing or misplaced BC0 clears `locked_o`, sets the sticky `sync_lost_o` and restarts measurement.
- R8: `cfg_clear_i` clears lock, latency, retry count, `retry_err_o` and `sync_lost_o` on all links, and the effect is visible on the next clock.
- R9: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| local_bc0_i | input | 1 | Local orbit marker, one cycle per orbit |
| link_data_i | input | N_LINKS*DW | Deserialised words, link k in bits k*DW upward |
| link_bc0_i | input | N_LINKS | In-band BC0 flag of each link |
| cfg_short_lat_i | input | N_LINKS*LAT_W | Expected short latency per link |
| cfg_target_i | input | LAT_W | Common target latency |
| cfg_clear_i | input | 1 | Restart all links and clear status |
| aln_data_o | output | N_LINKS*DW | Aligned words |
| aln_bc0_o | output | N_LINKS | Aligned BC0 flags |
| deser_rst_o | output | N_LINKS | One-clock deserialiser reset request |
| locked_o | output | N_LINKS | Link aligned |
| retry_err_o | output | N_LINKS | Retry cap reached, locked at long latency |
| sync_lost_o | output | N_LINKS | Sticky loss-of-sync |
| link_lat_o | output | N_LINKS*LAT_W | Accepted latency per link |

## Verification
The hardest state to reach is the retry cap. A real deserialiser would have to choose the long latency seventeen times in a row, which random choice almost never produces. The bench's deserialiser model therefore has a forced-long mode that drives one link through all sixteen resets to the error lock. Other links run with random latencies chosen from a fixed seed. The four-orbit acceptance rule is exercised by a directed test: one BC0 is dropped at a known orbit after a clear, and the lock time that follows is checked to the orbit.

// File: rtl/lat_align_pkg.sv
package lat_align_pkg;

    localparam int LAT_W   = 4;
    localparam int RETRY_W = 5;
    localparam int MATCH_W = 3;

    typedef enum logic {
        ST_MEASURE = 1'b0,
        ST_LOCKED  = 1'b1
    } lock_st_e;

    typedef struct packed {
        lock_st_e           st;
        logic [LAT_W-1:0]   prev;
        logic [MATCH_W-1:0] match;
        logic [LAT_W-1:0]   lat;
        logic [RETRY_W-1:0] retry;
        logic               seen;
        logic               rst_req;
        logic               err;
        logic               los;
    } lock_regs_t;

    typedef struct packed {
        logic [LAT_W-1:0] cnt;
        logic             armed;
    } phase_regs_t;

endpackage

// File: rtl/orbit_phase.sv
module orbit_phase
    import lat_align_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             local_bc0_i,
    output logic [LAT_W-1:0] phase_o,
    output logic             armed_o
);

    localparam logic [LAT_W-1:0] PH_SAT = '1;

    phase_regs_t q, d;

    always_comb begin
        d = q;
        if (local_bc0_i) begin
            d.cnt = '0;
        end else if (q.cnt != PH_SAT) begin
            d.cnt = q.cnt + 1'b1;
        end
        d.armed = q.armed | local_bc0_i;
    end

    assign phase_o = d.cnt;
    assign armed_o = q.armed;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.cnt   <= PH_SAT;
            q.armed <= 1'b0;
        end else begin
            q <= d;
        end
    end

    AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        local_bc0_i |=> (q.cnt == '0) && q.armed); // R1

    AST_PHASE_HOLD_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.cnt == PH_SAT && !local_bc0_i) |=> q.cnt == PH_SAT); // R1

endmodule

// File: rtl/link_lock.sv
module link_lock
    import lat_align_pkg::*;
#(
    parameter int MATCH_N   = 4,
    parameter int MAX_RETRY = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             local_bc0_i,
    input  logic [LAT_W-1:0] phase_i,
    input  logic             armed_i,
    input  logic             link_bc0_i,
    input  logic [LAT_W-1:0] short_lat_i,
    input  logic             clear_i,
    output logic [LAT_W-1:0] lat_o,
    output logic             locked_o,
    output logic             rst_req_o,
    output logic             err_o,
    output logic             los_o
);

    localparam logic [LAT_W-1:0]   PH_SAT    = '1;
    localparam logic [MATCH_W-1:0] MATCH_END = MATCH_W'(MATCH_N);
    localparam logic [RETRY_W-1:0] RETRY_CAP = RETRY_W'(MAX_RETRY);

    lock_regs_t q, d;
    logic               missing;
    logic               in_win;
    logic [MATCH_W-1:0] match_base;
    logic [MATCH_W-1:0] next_match;

    always_comb begin
        d          = q;
        d.rst_req  = 1'b0;
        d.seen     = local_bc0_i ? link_bc0_i : (q.seen | link_bc0_i);
        missing    = armed_i & local_bc0_i & ~q.seen;
        in_win     = (phase_i != PH_SAT);
        match_base = missing ? '0 : q.match;
        next_match = '0;

        if (clear_i) begin
            d.st    = ST_MEASURE;
            d.match = '0;
            d.retry = '0;
            d.lat   = '0;
            d.err   = 1'b0;
            d.los   = 1'b0;
        end else if (q.st == ST_MEASURE) begin
            d.match = match_base;
            if (armed_i && link_bc0_i && in_win) begin
                if (match_base != '0 && phase_i == q.prev) begin
                    next_match = match_base + 1'b1;
                end else begin
                    next_match = MATCH_W'(1);
                end
                d.prev = phase_i;
                if (next_match == MATCH_END) begin
                    d.match = '0;
                    if (phase_i == short_lat_i) begin
                        d.st    = ST_LOCKED;
                        d.lat   = phase_i;
                        d.retry = '0;
                    end else if (q.retry == RETRY_CAP) begin
                        d.st  = ST_LOCKED;
                        d.lat = phase_i;
                        d.err = 1'b1;
                    end else begin
                        d.rst_req = 1'b1;
                        d.retry   = q.retry + 1'b1;
                    end
                end else begin
                    d.match = next_match;
                end
            end
        end else begin
            if (armed_i && ((phase_i == q.lat) != link_bc0_i)) begin
                d.st    = ST_MEASURE;
                d.los   = 1'b1;
                d.match = '0;
                d.lat   = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lat_o     = q.lat;
    assign locked_o  = (q.st == ST_LOCKED);
    assign rst_req_o = q.rst_req;
    assign err_o     = q.err;
    assign los_o     = q.los;

    AST_RST_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.rst_req |=> !q.rst_req); // R4

    AST_RETRY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.retry <= RETRY_CAP); // R5

    AST_ERR_AT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.err) |-> ($past(q.retry) == RETRY_CAP) && (q.st == ST_LOCKED)); // R5

    AST_LOCK_IS_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_LOCKED && !q.err) |-> q.lat == short_lat_i); // R3

    AST_LOS_FROM_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.los) |-> $past(q.st) == ST_LOCKED); // R7

endmodule

// File: rtl/link_delay.sv
module link_delay
    import lat_align_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DW-1:0]    data_i,
    input  logic             bc0_i,
    input  logic [LAT_W-1:0] dly_i,
    output logic [DW-1:0]    data_o,
    output logic             bc0_o
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [LAT_W-1:0] DLY_MAX = LAT_W'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [DW:0]   word;
    } dl_regs_t;

    dl_regs_t q, d;
    logic [DW:0]   mem [DEPTH];
    logic [PW-1:0] eff;
    logic [PW-1:0] rd;

    always_comb begin
        d    = q;
        eff  = (dly_i > DLY_MAX) ? PW'(DEPTH - 1) : dly_i[PW-1:0];
        rd   = q.wr - eff;
        d.wr = q.wr + 1'b1;
        if (eff == '0) begin
            d.word = {bc0_i, data_i};
        end else begin
            d.word = mem[rd];
        end
    end

    always_ff @(posedge clk_i) begin
        mem[q.wr] <= {bc0_i, data_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_o = q.word[DW-1:0];
    assign bc0_o  = q.word[DW];

endmodule

// File: rtl/latency_aligner.sv
module latency_aligner
    import lat_align_pkg::*;
#(
    parameter int N_LINKS   = 3,
    parameter int DW        = 8,
    parameter int DEPTH     = 8,
    parameter int MATCH_N   = 4,
    parameter int MAX_RETRY = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       local_bc0_i,
    input  logic [N_LINKS*DW-1:0]      link_data_i,
    input  logic [N_LINKS-1:0]         link_bc0_i,
    input  logic [N_LINKS*LAT_W-1:0]   cfg_short_lat_i,
    input  logic [LAT_W-1:0]           cfg_target_i,
    input  logic                       cfg_clear_i,
    output logic [N_LINKS*DW-1:0]      aln_data_o,
    output logic [N_LINKS-1:0]         aln_bc0_o,
    output logic [N_LINKS-1:0]         deser_rst_o,
    output logic [N_LINKS-1:0]         locked_o,
    output logic [N_LINKS-1:0]         retry_err_o,
    output logic [N_LINKS-1:0]         sync_lost_o,
    output logic [N_LINKS*LAT_W-1:0]   link_lat_o
);

    localparam logic [LAT_W-1:0] DLY_MAX = LAT_W'(DEPTH - 1);

    logic [LAT_W-1:0] phase;
    logic             armed;

    orbit_phase u_phase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .local_bc0_i (local_bc0_i),
        .phase_o     (phase),
        .armed_o     (armed)
    );

    for (genvar k = 0; k < N_LINKS; k++) begin : g_link
        logic [LAT_W-1:0] lat;
        logic [LAT_W-1:0] dly;

        link_lock #(
            .MATCH_N   (MATCH_N),
            .MAX_RETRY (MAX_RETRY)
        ) u_lock (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .local_bc0_i (local_bc0_i),
            .phase_i     (phase),
            .armed_i     (armed),
            .link_bc0_i  (link_bc0_i[k]),
            .short_lat_i (cfg_short_lat_i[k*LAT_W +: LAT_W]),
            .clear_i     (cfg_clear_i),
            .lat_o       (lat),
            .locked_o    (locked_o[k]),
            .rst_req_o   (deser_rst_o[k]),
            .err_o       (retry_err_o[k]),
            .los_o       (sync_lost_o[k])
        );

        always_comb begin
            dly = (lat > cfg_target_i) ? '0 : (cfg_target_i - lat);
        end

        link_delay #(
            .DW    (DW),
            .DEPTH (DEPTH)
        ) u_delay (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .data_i (link_data_i[k*DW +: DW]),
            .bc0_i  (link_bc0_i[k]),
            .dly_i  (dly),
            .data_o (aln_data_o[k*DW +: DW]),
            .bc0_o  (aln_bc0_o[k])
        );

        assign link_lat_o[k*LAT_W +: LAT_W] = lat;

        AST_DLY_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            locked_o[k] |-> dly <= DLY_MAX); // R6
    end

    AST_ALIGNED_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((&locked_o) && $past(&locked_o)) |-> (aln_bc0_o == '0 || aln_bc0_o == '1)); // R6

endmodule

// File: tb/latency_aligner_bench.sv
module latency_aligner_bench;
    import lat_align_pkg::*;

    localparam int CLK_P = 10;
    localparam int NL    = 3;
    localparam int DW    = 8;
    localparam int LW    = LAT_W;
    localparam int ORB   = 20;
    localparam int TGT   = 9;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic              rst_n;
    logic              local_bc0;
    logic [NL*DW-1:0]  link_data;
    logic [NL-1:0]     link_bc0;
    logic [NL*LW-1:0]  cfg_short;
    logic [LW-1:0]     cfg_target;
    logic              cfg_clear;
    logic [NL*DW-1:0]  aln_data;
    logic [NL-1:0]     aln_bc0;
    logic [NL-1:0]     deser_rst;
    logic [NL-1:0]     locked;
    logic [NL-1:0]     retry_err;
    logic [NL-1:0]     sync_lost;
    logic [NL*LW-1:0]  link_lat;

    latency_aligner u_latency_aligner (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .local_bc0_i     (local_bc0),
        .link_data_i     (link_data),
        .link_bc0_i      (link_bc0),
        .cfg_short_lat_i (cfg_short),
        .cfg_target_i    (cfg_target),
        .cfg_clear_i     (cfg_clear),
        .aln_data_o      (aln_data),
        .aln_bc0_o       (aln_bc0),
        .deser_rst_o     (deser_rst),
        .locked_o        (locked),
        .retry_err_o     (retry_err),
        .sync_lost_o     (sync_lost),
        .link_lat_o      (link_lat)
    );

    int fib [NL] = '{0, 1, 2};
    int dlat[NL];
    int mode[NL];       // 0 random, 1 forced short, 2 forced long
    int rst_cnt[NL];
    int n;
    int errs;
    int checks;
    int g_link;
    int g_orb;
    int g_kind;         // 0 drop, 1 one clock late
    bit clr_req;
    bit prev_all;
    logic [NL-1:0] prev_rst;

    function automatic int w(int s, int i);
        return (s * 7 + i * 53 + 11) & 255;
    endfunction

    function automatic int lat_of(int i);
        return fib[i] + dlat[i];
    endfunction

    function automatic bit src_bc0(int i, int nn);
        int s;
        s = nn - lat_of(i);
        if (s < 0) return 1'b0;
        if (i == g_link && s / ORB == g_orb) return (g_kind == 1) && (s % ORB == 1);
        return (s % ORB) == 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive();
        local_bc0 = (n % ORB) == 0;
        for (int i = 0; i < NL; i++) begin
            int s;
            s = n - lat_of(i);
            link_bc0[i] = src_bc0(i, n);
            link_data[i*DW +: DW] = (s < 0) ? '0 : DW'(w(s, i));
        end
        cfg_clear = clr_req;
        clr_req   = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            if (deser_rst[i]) begin
                rst_cnt[i]++;
                check(dlat[i] == 3, "R4 reset only on long latency", dlat[i], 3);
                check(!prev_rst[i], "R4 reset pulse one clock", int'(prev_rst[i]), 0);
                if (mode[i] == 0) dlat[i] = 2 + int'($urandom % 2);
                else if (mode[i] == 1) dlat[i] = 2;
                else dlat[i] = 3;
            end
        end
        prev_rst = deser_rst;
        if ((&locked) && prev_all && (n - TGT >= 0)) begin
            for (int i = 0; i < NL; i++) begin
                check(aln_data[i*DW +: DW] == DW'(w(n - TGT, i)), "R6 aligned data",
                      int'(aln_data[i*DW +: DW]), w(n - TGT, i));
                check(aln_bc0[i] == (((n - TGT) % ORB) == 0), "R6 aligned bc0",
                      int'(aln_bc0[i]), int'(((n - TGT) % ORB) == 0));
            end
        end
        prev_all = &locked;
        n++;
        drive();
    endtask

    task automatic run(int k);
        repeat (k) step();
    endtask

    task automatic wait_all(int limit);
        int t;
        t = 0;
        while (!(&locked) && t < limit) begin
            step();
            t++;
        end
        check(&locked, "R3 all links lock", int'(locked), (1 << NL) - 1);
    endtask

    task automatic pulse_clear();
        clr_req = 1'b1;
        step();
        step();
    endtask

    initial begin
        #(CLK_P * 200000);
        errs++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        errs = 0; checks = 0; n = 0; g_link = -1; g_orb = 0; g_kind = 0;
        clr_req = 1'b0; prev_all = 1'b0; prev_rst = '0;
        for (int i = 0; i < NL; i++) begin
            mode[i]    = (i == 2) ? 1 : 0;
            dlat[i]    = (i == 2) ? 2 : 2 + int'($urandom % 2);
            rst_cnt[i] = 0;
            cfg_short[i*LW +: LW] = LW'(fib[i] + 2);
        end
        cfg_target = LW'(TGT);
        rst_n = 1'b0; local_bc0 = 1'b0; link_bc0 = '0; link_data = '0; cfg_clear = 1'b0;
        repeat (4) @(negedge clk);

        // R9: reset values
        check(aln_data == '0 && aln_bc0 == '0, "R9 aligned outputs in reset", int'(aln_bc0), 0);
        check(deser_rst == '0 && locked == '0, "R9 reset and lock in reset", int'(locked), 0);
        check(retry_err == '0 && sync_lost == '0, "R9 status in reset", int'(sync_lost), 0);
        check(link_lat == '0, "R9 latency in reset", int'(link_lat), 0);

        rst_n = 1'b1;
        drive();

        // R1 R3: initial lock with random deserialiser choices
        wait_all(3000);
        for (int i = 0; i < NL; i++) begin
            check(retry_err[i] == 1'b0, "R3 no retry error", int'(retry_err[i]), 0);
            check(int'(link_lat[i*LW +: LW]) == fib[i] + 2, "R1 accepted latency",
                  int'(link_lat[i*LW +: LW]), fib[i] + 2);
        end
        check(rst_cnt[2] == 0, "R3 no reset on short link", rst_cnt[2], 0);
        run(120);   // R6 checks inside step

        // R7: misplaced BC0 on locked link 1
        g_link = 1; g_kind = 1; g_orb = n / ORB + 2;
        while (n < g_orb * ORB + 7) step();
        check(sync_lost[1] == 1'b1, "R7 sync lost raised", int'(sync_lost[1]), 1);
        check(locked[1] == 1'b0, "R7 lock dropped", int'(locked[1]), 0);
        check(sync_lost[0] == 1'b0, "R7 other link untouched", int'(sync_lost[0]), 0);
        g_link = -1;
        wait_all(1000);
        check(sync_lost[1] == 1'b1, "R7 sync lost sticky", int'(sync_lost[1]), 1);
        run(60);

        // R8: clear
        pulse_clear();
        check(sync_lost == '0, "R8 sync lost cleared", int'(sync_lost), 0);
        check(locked == '0, "R8 lock cleared", int'(locked), 0);
        check(link_lat == '0, "R8 latency cleared", int'(link_lat), 0);

        // R2: dropped BC0 restarts the four-orbit count (link 2, latency 4)
        begin
            int k0;
            int l2;
            while (n % ORB != 9) step();
            k0 = n / ORB;
            l2 = lat_of(2);
            g_link = 2; g_kind = 0; g_orb = k0 + 2;
            clr_req = 1'b1;
            step();
            while (n < ORB * (k0 + 5) + l2 + 4) step();
            check(locked[2] == 1'b0, "R2 no lock after drop", int'(locked[2]), 0);
            while (n < ORB * (k0 + 6) + l2 + 4) step();
            check(locked[2] == 1'b1, "R2 lock after four matching orbits", int'(locked[2]), 1);
            g_link = -1;
        end
        wait_all(3000);
        run(60);

        // R5: link 2 always comes up long
        mode[2] = 2; dlat[2] = 3; rst_cnt[2] = 0;
        pulse_clear();
        begin
            int t;
            t = 0;
            while (!retry_err[2] && t < 5000) begin
                step();
                t++;
            end
        end
        check(retry_err[2] == 1'b1, "R5 retry error raised", int'(retry_err[2]), 1);
        check(rst_cnt[2] == 16, "R5 reset count at cap", rst_cnt[2], 16);
        check(locked[2] == 1'b1, "R5 locked at long latency", int'(locked[2]), 1);
        check(int'(link_lat[2*LW +: LW]) == fib[2] + 3, "R1 long latency reported",
              int'(link_lat[2*LW +: LW]), fib[2] + 3);
        wait_all(3000);
        run(150);
        check(rst_cnt[2] == 16, "R5 no reset after cap", rst_cnt[2], 16);
        pulse_clear();
        check(retry_err == '0, "R8 retry error cleared", int'(retry_err), 0);

        // random rounds
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < NL; i++) mode[i] = 0;
            run(int'($urandom % ORB));
            pulse_clear();
            wait_all(3000);
            for (int i = 0; i < NL; i++) begin
                check(retry_err[i] == 1'b0, "R3 random round no error", int'(retry_err[i]), 0);
                check(int'(link_lat[i*LW +: LW]) == fib[i] + 2, "R1 random round latency",
                      int'(link_lat[i*LW +: LW]), fib[i] + 2);
            end
            run(60);
        end

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule